// File: doc/BRIEF.md
# Guarded Host Register Bank

This block holds a set of 16-bit control registers that a host processor reaches through an asynchronous port. The port has an 8-bit address, a 16-bit write-data input, a 16-bit read-data output with an output-enable (together they form the bidirectional data bus at the pad ring), and active-low chip-select, read and write strobes. The three strobes are brought into the core clock domain through a multi-flop synchroniser. A write takes effect on the rising edge of the synchronised write strobe. It uses the address and data sampled while the strobe was low, and it only counts if chip select was low at that time.

Every address has an acceptance rule. Most registers take a write at any time. Two status slots can only be read, and they show live status inputs. The two timer reload registers take a write only while the timer is stopped. The interrupt-routing register takes a write only after an interrupt has been raised, and an accepted write uses up that permission. The I/O-mode register takes a write only once a sample tick has been seen since reset. The decimation register takes a write at any time, but each such write marks the outputs invalid for a fixed number of sample ticks. A write that breaks its rule is discarded without error, and a one-cycle reject pulse reports it. Addresses above the mapped range read as zero and take no writes.

The core sees every register value on a flat bus. The timer, the interrupt source and the sample clock appear only as simple status inputs, synchronous to the core clock.

Top module: `guarded_regbank`

## Requirements
- R1: After reset every writable register holds zero, the read output and its enable are low, the invalid flag is low, and no accept or reject pulse is seen.
- R2: A write to an always-writable address (0, 1, 2, 3, 5, 7, 8, 10, 12, 15 to 20) is stored and is returned by a later read of that address, with the read enable high during the read.
- R3: Addresses 6 and 11 return the live status inputs `stat_rev` and `stat_pwr`; a write to either is discarded and raises the reject pulse.
- R4: Writes to addresses 13 and 14 are stored only while `timer_running` is 0; otherwise they are discarded with a reject pulse.
- R5: A write to address 4 is stored only if an `irq_evt` pulse has come since the last accepted write to address 4 (or since reset); a second write without a fresh interrupt is discarded.
- R6: A write to address 9 is discarded until at least one `smp_tick` pulse has been seen since reset, and is stored after that.
- R7: An accepted write to address 12 sets `out_invalid` in the same cycle as its accept pulse; the flag stays high until SETTLE_SAMPLES `smp_tick` pulses have followed the write, then clears.
- R8: Addresses 21 to 255 read as zero, and writes to them are discarded with a reject pulse.
- R9: Every committed write gives exactly one single-cycle pulse, either `wr_accept` or `wr_reject`, never both.
- R10: A write strobe issued while chip select is high commits nothing: no pulse, and no register changes.
- R11: `host_rdata_oe` is high only while both chip select and read strobe are (synchronised) low; otherwise `host_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Asynchronous chip select, active low |
| host_rd_n | input | 1 | Asynchronous read strobe, active low |
| host_wr_n | input | 1 | Asynchronous write strobe, active low |
| host_addr | input | 8 | Register address |
| host_wdata | input | 16 | Write data from the host |
| host_rdata | output | 16 | Read data to the host (zero when not enabled) |
| host_rdata_oe | output | 1 | Enable for the read-data pad drivers |
| timer_running | input | 1 | High while the internal timer runs |
| irq_evt | input | 1 | One-cycle pulse when the device raises an interrupt |
| smp_tick | input | 1 | One-cycle pulse per input sample clock |
| stat_rev | input | 16 | Status value shown at address 6 |
| stat_pwr | input | 16 | Status value shown at address 11 |
| wr_accept | output | 1 | One-cycle pulse: a write was stored |
| wr_reject | output | 1 | One-cycle pulse: a write was discarded |
| out_invalid | output | 1 | Outputs unsettled after a decimation change |
| cfg_regs | output | 336 | All 21 register values, address k at bits 16k+15 down to 16k |

## Verification
The bench builds the block with its default shape: 21 mapped registers, a two-stage synchroniser and a settle window of four sample ticks. A four-tick window makes both edges of the invalid flag reachable in a few dozen cycles. With an 8-bit address, all 256 locations can be written and read back in one sweep. The sweep runs with every guard condition unmet, so each rule's refusal and every unmapped slot are checked against an arithmetic pattern. Targeted sequences then meet each guard in turn, use up and renew the interrupt permission, and issue strobes with chip select high.

// File: rtl/grb_pkg.sv
// Package: shared address constants and the per-address write policy.
// Assumes an 8-bit host address; addresses above LAST_MAPPED are unmapped.
package grb_pkg;

    typedef enum logic [2:0] {
        POL_FREE,
        POL_RDONLY,
        POL_TMR_OFF,
        POL_AFTER_IRQ,
        POL_AFTER_CLK,
        POL_UNMAPPED
    } policy_e;

    localparam int unsigned A_IRQMAP    = 4;
    localparam int unsigned A_REV       = 6;
    localparam int unsigned A_IOMODE    = 9;
    localparam int unsigned A_PWRSTAT   = 11;
    localparam int unsigned A_DECIM     = 12;
    localparam int unsigned A_TMR_HI    = 13;
    localparam int unsigned A_TMR_LO    = 14;
    localparam int unsigned LAST_MAPPED = 20;

    // Map an address to the rule that governs host writes to it.
    function automatic policy_e policy_of(input int unsigned a);
        policy_e p;
        if (a > LAST_MAPPED)                  p = POL_UNMAPPED;
        else if (a == A_REV || a == A_PWRSTAT) p = POL_RDONLY;
        else if (a == A_TMR_HI || a == A_TMR_LO) p = POL_TMR_OFF;
        else if (a == A_IRQMAP)               p = POL_AFTER_IRQ;
        else if (a == A_IOMODE)               p = POL_AFTER_CLK;
        else                                  p = POL_FREE;
        return p;
    endfunction

endpackage

// File: rtl/grb_host_sync.sv
// Host port synchroniser.
// Brings the asynchronous strobes into the core clock through STAGES flops,
// samples address/data while the synchronised write strobe is low, and
// emits a one-cycle commit on its rising edge if chip select was low.
// Assumes the host holds address and data stable from the falling edge of
// the write strobe until STAGES+1 core cycles after its rising edge.
module grb_host_sync #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cmt_pulse,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [DATA_W-1:0] cmt_data,
    output logic              rd_active
);

    logic [STAGES-1:0] cs_sh;
    logic [STAGES-1:0] wr_sh;
    logic [STAGES-1:0] rd_sh;
    logic              wr_prev;
    logic              cap_sel;
    logic              cs_s;
    logic              wr_s;
    logic              rd_s;

    assign cs_s = cs_sh[STAGES-1];
    assign wr_s = wr_sh[STAGES-1];
    assign rd_s = rd_sh[STAGES-1];

    // Shift the raw strobes through the synchroniser chains (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sh   <= '1;
            wr_sh   <= '1;
            rd_sh   <= '1;
            wr_prev <= 1'b1;
        end else begin
            cs_sh   <= {cs_sh[STAGES-2:0], cs_n};
            wr_sh   <= {wr_sh[STAGES-2:0], wr_n};
            rd_sh   <= {rd_sh[STAGES-2:0], rd_n};
            wr_prev <= wr_s;
        end
    end

    // Track address, data and selection while the write strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmt_addr <= '0;
            cmt_data <= '0;
            cap_sel  <= 1'b0;
        end else if (!wr_s) begin
            cmt_addr <= addr;
            cmt_data <= wdata;
            cap_sel  <= !cs_s;
        end
    end

    assign cmt_pulse = wr_s && !wr_prev && cap_sel;
    assign rd_active = !cs_s && !rd_s;

endmodule

// File: rtl/grb_write_guard.sv
// Write guard.
// Decides whether a committed write is stored or discarded, using the
// address policy and live device state. Holds the sticky "interrupt raised"
// and "sample clock seen" flags. Status inputs are synchronous to clk.
module grb_write_guard #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmt_pulse,
    input  logic [ADDR_W-1:0] cmt_addr,
    input  logic              timer_running,
    input  logic              irq_evt,
    input  logic              smp_tick,
    output logic              do_write,
    output logic              do_reject,
    output logic              irq_pending,
    output logic              clk_seen
);
    import grb_pkg::*;

    policy_e pol;
    logic    allowed;

    // Evaluate the policy of the committed address against device state.
    always_comb begin
        pol = policy_of(int'(cmt_addr));
        unique case (pol)
            POL_FREE:      allowed = 1'b1;
            POL_TMR_OFF:   allowed = !timer_running;
            POL_AFTER_IRQ: allowed = irq_pending;
            POL_AFTER_CLK: allowed = clk_seen;
            default:       allowed = 1'b0;
        endcase
    end

    assign do_write  = cmt_pulse && allowed;
    assign do_reject = cmt_pulse && !allowed;

    // Sticky interrupt flag: a fresh interrupt wins over consumption.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_pending <= 1'b0;
        else if (irq_evt)
            irq_pending <= 1'b1;
        else if (do_write && int'(cmt_addr) == A_IRQMAP)
            irq_pending <= 1'b0;
    end

    // Sticky flag recording that a sample clock has been observed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_seen <= 1'b0;
        else if (smp_tick)
            clk_seen <= 1'b1;
    end

endmodule

// File: rtl/grb_reg_store.sv
// Register storage and read multiplexer.
// One storage word per writable address (generated); read-only slots show
// the status inputs instead. Reads beyond NUM_REGS return zero.
module grb_reg_store #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 21
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       do_write,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [DATA_W-1:0]          stat_rev,
    input  logic [DATA_W-1:0]          stat_pwr,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat,
    output logic [DATA_W-1:0]          rd_value
);
    import grb_pkg::*;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        logic [DATA_W-1:0] q;
        if (i == A_REV) begin : g_rev
            assign q = stat_rev;
        end else if (i == A_PWRSTAT) begin : g_pwr
            assign q = stat_pwr;
        end else begin : g_rw
            // Store the host word when the guard accepts a write here.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (do_write && waddr == ADDR_W'(i))
                    q <= wdata;
            end
        end
        assign regs_flat[i*DATA_W +: DATA_W] = q;
    end

    // Select the addressed word, zero for unmapped addresses.
    always_comb begin
        rd_value = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == ADDR_W'(k))
                rd_value = regs_flat[k*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/grb_settle_timer.sv
// Settle timer.
// Loaded by an accepted decimation write; counts down on sample ticks and
// flags outputs invalid until COUNT ticks have passed. A load wins over a
// tick in the same cycle.
module grb_settle_timer #(
    parameter int COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic busy
);
    localparam int CW = $clog2(COUNT + 1);

    logic [CW-1:0] cnt;

    // Reload on a decimation change, otherwise count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CW'(COUNT);
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/guarded_regbank.sv
// Guarded host register bank (top).
// Synchronises the host port, applies per-address write policies, stores
// the registers, drives registered read data and reports each commit as
// an accept or reject pulse. Assumes status inputs are synchronous to clk.
module guarded_regbank #(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 16,
    parameter int NUM_REGS       = 21,
    parameter int SYNC_STAGES    = 2,
    parameter int SETTLE_SAMPLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_cs_n,
    input  logic                       host_rd_n,
    input  logic                       host_wr_n,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    output logic                       host_rdata_oe,
    input  logic                       timer_running,
    input  logic                       irq_evt,
    input  logic                       smp_tick,
    input  logic [DATA_W-1:0]          stat_rev,
    input  logic [DATA_W-1:0]          stat_pwr,
    output logic                       wr_accept,
    output logic                       wr_reject,
    output logic                       out_invalid,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    import grb_pkg::*;

    logic              cmt_pulse;
    logic [ADDR_W-1:0] cmt_addr;
    logic [DATA_W-1:0] cmt_data;
    logic              rd_active;
    logic              do_write;
    logic              do_reject;
    logic              irq_pending;
    logic              clk_seen;
    logic [DATA_W-1:0] rd_value;
    logic [ADDR_W-1:0] evt_addr;

    grb_host_sync #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (host_cs_n),
        .wr_n      (host_wr_n),
        .rd_n      (host_rd_n),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .cmt_pulse (cmt_pulse),
        .cmt_addr  (cmt_addr),
        .cmt_data  (cmt_data),
        .rd_active (rd_active)
    );

    grb_write_guard #(
        .ADDR_W (ADDR_W)
    ) u_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmt_pulse     (cmt_pulse),
        .cmt_addr      (cmt_addr),
        .timer_running (timer_running),
        .irq_evt       (irq_evt),
        .smp_tick      (smp_tick),
        .do_write      (do_write),
        .do_reject     (do_reject),
        .irq_pending   (irq_pending),
        .clk_seen      (clk_seen)
    );

    grb_reg_store #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_write  (do_write),
        .waddr     (cmt_addr),
        .wdata     (cmt_data),
        .rd_addr   (host_addr),
        .stat_rev  (stat_rev),
        .stat_pwr  (stat_pwr),
        .regs_flat (cfg_regs),
        .rd_value  (rd_value)
    );

    grb_settle_timer #(
        .COUNT (SETTLE_SAMPLES)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_write && int'(cmt_addr) == A_DECIM),
        .tick  (smp_tick),
        .busy  (out_invalid)
    );

    // Register the read bus and its enable; zero when not selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata    <= '0;
            host_rdata_oe <= 1'b0;
        end else begin
            host_rdata    <= rd_active ? rd_value : '0;
            host_rdata_oe <= rd_active;
        end
    end

    // Report the outcome of each committed write with its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_accept <= 1'b0;
            wr_reject <= 1'b0;
            evt_addr  <= '0;
        end else begin
            wr_accept <= do_write;
            wr_reject <= do_reject;
            if (cmt_pulse)
                evt_addr <= cmt_addr;
        end
    end

endmodule

// File: rtl/grb_chk.sv
// Checker for the guarded register bank: relates accept/reject outcomes
// to the device state seen by the guard one cycle earlier.
module grb_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_accept,
    input logic              wr_reject,
    input logic [ADDR_W-1:0] evt_addr,
    input logic              timer_running,
    input logic              irq_pending,
    input logic              clk_seen,
    input logic              out_invalid
);

    // R9
    acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_accept && wr_reject));

    // R9
    acc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !wr_accept);

    // R3
    ro_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (int'(evt_addr) != 6 && int'(evt_addr) != 11));

    // R8
    unmapped_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> int'(evt_addr) <= 20);

    // R4
    tmr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && (int'(evt_addr) == 13 || int'(evt_addr) == 14))
        |-> !$past(timer_running));

    // R5
    irq_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && int'(evt_addr) == 4) |-> $past(irq_pending));

    // R6
    clk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && int'(evt_addr) == 9) |-> $past(clk_seen));

    // R7
    settle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && int'(evt_addr) == 12) |-> out_invalid);

endmodule

bind guarded_regbank grb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_accept     (wr_accept),
    .wr_reject     (wr_reject),
    .evt_addr      (evt_addr),
    .timer_running (timer_running),
    .irq_pending   (irq_pending),
    .clk_seen      (clk_seen),
    .out_invalid   (out_invalid)
);

// File: tb/guarded_regbank_tb.sv
`timescale 1ns/1ps
module guarded_regbank_tb;

    localparam int NREG   = 21;
    localparam int SETTLE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              rd_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [7:0]        addr = '0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              rdata_oe;
    logic              timer_running = 1'b1;
    logic              irq_evt = 1'b0;
    logic              smp_tick = 1'b0;
    logic [15:0]       stat_rev = 16'h1A2B;
    logic [15:0]       stat_pwr = 16'h00C3;
    logic              acc;
    logic              rej;
    logic              invalid;
    logic [NREG*16-1:0] cfg;

    int total = 0;
    int bad = 0;
    int n_acc = 0;
    int n_rej = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    guarded_regbank #(
        .ADDR_W (8), .DATA_W (16), .NUM_REGS (NREG),
        .SYNC_STAGES (2), .SETTLE_SAMPLES (SETTLE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .host_cs_n (cs_n), .host_rd_n (rd_n), .host_wr_n (wr_n),
        .host_addr (addr), .host_wdata (wdata),
        .host_rdata (rdata), .host_rdata_oe (rdata_oe),
        .timer_running (timer_running), .irq_evt (irq_evt),
        .smp_tick (smp_tick), .stat_rev (stat_rev), .stat_pwr (stat_pwr),
        .wr_accept (acc), .wr_reject (rej), .out_invalid (invalid),
        .cfg_regs (cfg)
    );

    // Count outcome pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && acc) n_acc++;
        if (rst_n && rej) n_rej++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [15:0] d, input bit sel = 1'b1);
        @(negedge clk);
        addr = a; wdata = d; cs_n = !sel; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_read(input logic [7:0] a, output logic [15:0] d, output logic oe,
                             input bit sel = 1'b1);
        @(negedge clk);
        addr = a; cs_n = !sel; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = rdata; oe = rdata_oe;
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk); smp_tick = 1'b1;
        @(negedge clk); smp_tick = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk); irq_evt = 1'b1;
        @(negedge clk); irq_evt = 1'b0;
    endtask

    function automatic logic [15:0] pat(input int a, input int salt);
        return {8'(~a), 8'(a)} ^ 16'(salt * 16'h0101);
    endfunction

    function automatic bit is_free(input int a);
        return a <= 20 && a != 4 && a != 6 && a != 9 && a != 11 && a != 13 && a != 14;
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic        oe;
        int          a0;
        int          r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk("R1 oe", 32'(rdata_oe), 0);
        chk("R1 rdata", 32'(rdata), 0);
        chk("R1 invalid", 32'(invalid), 0);
        chk("R1 reg0", 32'(cfg[15:0]), 0);
        chk("R1 reg13", 32'(cfg[13*16 +: 16]), 0);
        chk("R1 pulses", 32'(n_acc + n_rej), 0);

        // Sweep all 256 addresses with every guard unmet (R2 R3 R4 R5 R6 R8 R9)
        for (int a = 0; a < 256; a++) host_write(8'(a), pat(a, 0));
        chk("R9 accept count", 32'(n_acc), 15);
        chk("R9 reject count", 32'(n_rej), 241);
        for (int a = 0; a < 256; a++) begin
            logic [15:0] e;
            host_read(8'(a), d, oe);
            if (a == 6) e = stat_rev;
            else if (a == 11) e = stat_pwr;
            else if (is_free(a)) e = pat(a, 0);
            else e = 16'h0;
            chk(a > 20 ? "R8 sweep" : (is_free(a) ? "R2 sweep" : "R3-guard sweep"), 32'(d), 32'(e));
            chk("R11 oe during read", 32'(oe), 1);
        end

        // R3: status slots are live and ignore writes
        stat_rev = 16'hBEEF;
        r0 = n_rej;
        host_write(8'd11, 16'h1234);
        chk("R3 reject pulse", 32'(n_rej - r0), 1);
        host_read(8'd6, d, oe);
        chk("R3 live rev", 32'(d), 32'h0000BEEF);
        host_read(8'd11, d, oe);
        chk("R3 pwr unchanged", 32'(d), 32'h000000C3);

        // R4: timer reload registers
        timer_running = 1'b0;
        host_write(8'd13, 16'hA013);
        host_write(8'd14, 16'hA014);
        host_read(8'd13, d, oe); chk("R4 hi stored", 32'(d), 32'h0000A013);
        host_read(8'd14, d, oe); chk("R4 lo stored", 32'(d), 32'h0000A014);
        timer_running = 1'b1;
        r0 = n_rej;
        host_write(8'd13, 16'h5555);
        chk("R4 reject pulse", 32'(n_rej - r0), 1);
        host_read(8'd13, d, oe); chk("R4 hi kept", 32'(d), 32'h0000A013);

        // R5: interrupt-gated register, permission consumed per write
        pulse_irq();
        host_write(8'd4, 16'h4401);
        host_read(8'd4, d, oe); chk("R5 first write", 32'(d), 32'h00004401);
        host_write(8'd4, 16'h4402);
        host_read(8'd4, d, oe); chk("R5 no fresh irq", 32'(d), 32'h00004401);
        pulse_irq();
        host_write(8'd4, 16'h4403);
        host_read(8'd4, d, oe); chk("R5 fresh irq", 32'(d), 32'h00004403);

        // R6: I/O mode after a sample tick
        host_write(8'd9, 16'h9901);
        host_read(8'd9, d, oe); chk("R6 before tick", 32'(d), 0);
        pulse_tick();
        host_write(8'd9, 16'h9902);
        host_read(8'd9, d, oe); chk("R6 after tick", 32'(d), 32'h00009902);

        // R7: decimation write sets invalid for SETTLE ticks
        a0 = n_acc;
        host_write(8'd12, 16'h0C0C);
        chk("R7 accepted", 32'(n_acc - a0), 1);
        chk("R7 invalid set", 32'(invalid), 1);
        for (int t = 0; t < SETTLE - 1; t++) pulse_tick();
        @(negedge clk);
        chk("R7 still invalid", 32'(invalid), 1);
        pulse_tick();
        @(negedge clk);
        chk("R7 cleared", 32'(invalid), 0);

        // R10: write strobe without chip select
        a0 = n_acc; r0 = n_rej;
        host_write(8'd0, 16'hDEAD, 1'b0);
        chk("R10 no pulse", 32'(n_acc + n_rej - a0 - r0), 0);
        host_read(8'd0, d, oe); chk("R10 reg0 kept", 32'(d), 32'(pat(0, 0)));

        // R11: read strobe without chip select
        host_read(8'd1, d, oe, 1'b0);
        chk("R11 oe low", 32'(oe), 0);
        chk("R11 rdata zero", 32'(d), 0);
        chk("R11 oe idle", 32'(rdata_oe), 0);

        // R2: second pattern across the always-writable set
        for (int a = 0; a <= 20; a++) if (is_free(a)) host_write(8'(a), pat(a, 3));
        for (int a = 0; a <= 20; a++) if (is_free(a)) begin
            host_read(8'(a), d, oe);
            chk("R2 rewrite", 32'(d), 32'(pat(a, 3)));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule